// File: doc/BRIEF.md
# Programmable Clock Divider with Clear

This block derives an output clock from an input clock. A static parameter picks the mode. In bypass the input clock passes straight through. Otherwise the input rate is divided by a whole number from 1 to 8, and every divided output changes on rising input edges only. An enable input decides when the division advances. An asynchronous clear forces the output low at once and restarts the division from the start of its cycle.

With an even divisor the two phases are equal. With an odd divisor the low phase is one input cycle longer than the high phase. Divide-by-1 is a gated copy of the input clock. It starts one input cycle after the enable is first seen, so it lags the bypass path.

The parameter `DIVIDE` uses the value 0 for bypass, which is the default. The values 1 to 8 give those divisors.

Top module: `clkdiv_top`

## Requirements
- R1: With DIVIDE = 0 (bypass), clk_out equals clk_in at all times, whatever the values of ce, clr and rst_n.
- R2: With DIVIDE = N in 2..8 and ce held high, clk_out repeats every N input cycles. It is high for N/2 cycles (rounded down) and low for the rest, so for odd N the low phase is one cycle longer.
- R3: With DIVIDE = 1, clk_out stays low through the first enabled rising edge. From the next rising input edge on, clk_out follows clk_in: high in each high phase of clk_in and low in each low phase.
- R4: For DIVIDE in 2..8, the first rising input edge that samples ce high after reset, after clear, or from the idle state drives clk_out high. Counting enabled edges from 1, clk_out after edge e is high when (e-1) mod N < N/2.
- R5: After reset, and before any rising edge samples ce high, clk_out is low for every DIVIDE from 1 to 8.
- R6: For DIVIDE in 2..8, a rising edge that samples ce low changes neither clk_out nor the position in the cycle. Once ce returns high, the pattern continues from where it stopped. For DIVIDE = 1, clk_out is low from the falling input edge after a rising edge samples ce low.
- R7: clr is active high and asynchronous. For DIVIDE 1..8, clk_out goes low as soon as clr rises, without waiting for an input edge, and stays low while clr is high.
- R8: When clr is released, division restarts from the beginning. The first enabled rising edge starts a full high phase, as in R4.
- R9: rst_n is a synchronous active-low reset. For DIVIDE 2..8, clk_out is low after the rising edge that samples rst_n low. For DIVIDE = 1, clk_out is low from the following falling input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided or passed through |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable; the division advances only on edges where it is high |
| clr | input | 1 | Asynchronous clear, active high; forces the output low and restarts the cycle |
| clk_out | output | 1 | Divided, gated or bypassed output clock |

## Verification
The hardest case to reach is a clear that arrives during a high phase of the output. Only then is the asynchronous drop visible, because a clear that lands in a low phase changes nothing at the port.

The bench runs all nine divider settings side by side. It counts enabled edges so that it knows where each divider is in its cycle. It steps until the divide-by-8 output is due high, then raises clr between input edges. It then samples the outputs before the next rising edge arrives.

Freezing with ce low is checked by comparing the held levels with the output on the cycles that follow. The continuation after ce returns high is checked against the running edge count.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants and helper functions for the clock divider.
// Assumes divisors are small integers; 0 encodes the pass-through mode.
package clkdiv_pkg;
    localparam int BYPASS_SEL = 0;
    localparam int MAX_DIV    = 8;
    localparam int CNT_W      = $clog2(MAX_DIV);

    // Number of input cycles the divided output spends high.
    function automatic int high_cycles(input int n);
        return n / 2;
    endfunction
endpackage

// File: rtl/clkdiv_count.sv
// Module: position counter for divisors 2..MAX_DIV.
// Counts enabled input edges modulo DIV. Async clr and sync rst_n both
// return it to zero. Assumes DIV is at least 2.
module clkdiv_count
    import clkdiv_pkg::*;
#(
    parameter int DIV = 2,
    parameter int CW  = CNT_W
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    // Advance the cycle position on enabled edges, wrap at DIV-1.
    always_ff @(posedge clk_in or posedge clr) begin
        if (clr) begin
            cnt <= '0;
        end else if (!rst_n) begin
            cnt <= '0;
        end else if (ce) begin
            if (cnt == LAST) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
        int'(cnt) < DIV); // R2

    AST_CNT_FREEZE: assert property (@(posedge clk_in) disable iff (!rst_n || clr)
        !ce |=> $stable(cnt)); // R6

    AST_CNT_CLEARED: assert property (@(posedge clk_in) disable iff (!rst_n)
        clr |-> cnt == '0); // R7
endmodule

// File: rtl/clkdiv_shape.sv
// Module: output phase register for divisors 2..MAX_DIV.
// Drives the output high for the first DIV/2 positions of each cycle,
// registered on the rising input edge. Assumes cnt comes from clkdiv_count.
module clkdiv_shape
    import clkdiv_pkg::*;
#(
    parameter int DIV = 2,
    parameter int CW  = CNT_W
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          clr,
    input  logic [CW-1:0] cnt,
    output logic          out_q
);
    localparam logic [CW-1:0] HI_LEN = CW'(high_cycles(DIV));

    // Register the output level for the position that is now being left.
    always_ff @(posedge clk_in or posedge clr) begin
        if (clr) begin
            out_q <= 1'b0;
        end else if (!rst_n) begin
            out_q <= 1'b0;
        end else if (ce) begin
            out_q <= (cnt < HI_LEN);
        end
    end

    AST_RISE_AT_START: assert property (@(posedge clk_in) disable iff (!rst_n || clr)
        $rose(out_q) |-> ($past(cnt) == '0) && $past(ce)); // R4

    AST_HOLD_NO_CE: assert property (@(posedge clk_in) disable iff (!rst_n || clr)
        !ce |=> $stable(out_q)); // R6

    AST_OUT_CLEARED: assert property (@(posedge clk_in) disable iff (!rst_n)
        clr |-> !out_q); // R7
endmodule

// File: rtl/clkdiv_gate.sv
// Module: glitch-free gate for divide-by-1.
// ce is sampled on the rising edge and re-timed on the falling edge, so
// the output only opens or closes while the input clock is low.
// clr closes the gate at once.
module clkdiv_gate (
    input  logic clk_in,
    input  logic rst_n,
    input  logic ce,
    input  logic clr,
    output logic clk_out
);
    logic run_q;
    logic run_n;

    // Sample the enable on the rising input edge.
    always_ff @(posedge clk_in or posedge clr) begin
        if (clr) begin
            run_q <= 1'b0;
        end else if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= ce;
        end
    end

    // Re-time the enable into the low phase of the input clock.
    always_ff @(negedge clk_in or posedge clr) begin
        if (clr) begin
            run_n <= 1'b0;
        end else begin
            run_n <= run_q;
        end
    end

    assign clk_out = clk_in & run_n;

    AST_GATE_CLOSED: assert property (@(posedge clk_in) disable iff (!rst_n || clr)
        !$past(ce) |-> !run_n); // R6

    AST_GATE_CLR: assert property (@(posedge clk_in) disable iff (!rst_n)
        clr |-> !run_n && !run_q); // R7
endmodule

// File: rtl/clkdiv_top.sv
// Module: programmable clock divider top.
// DIVIDE = 0 passes clk_in through, 1 gates it, and 2..MAX_DIV divide it.
// The divide value is fixed at build time.
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int DIVIDE = BYPASS_SEL
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic ce,
    input  logic clr,
    output logic clk_out
);
    generate
        if (DIVIDE == BYPASS_SEL) begin : g_bypass
            logic unused_ctrl;
            // Pass-through mode ignores every control input.
            assign unused_ctrl = ce ^ clr ^ rst_n;
            assign clk_out     = clk_in;
        end else if (DIVIDE == 1) begin : g_div1
            clkdiv_gate u_gate (
                .clk_in (clk_in),
                .rst_n  (rst_n),
                .ce     (ce),
                .clr    (clr),
                .clk_out(clk_out)
            );
        end else begin : g_divn
            logic [CNT_W-1:0] cnt;
            logic             out_q;

            clkdiv_count #(.DIV(DIVIDE), .CW(CNT_W)) u_count (
                .clk_in(clk_in),
                .rst_n (rst_n),
                .ce    (ce),
                .clr   (clr),
                .cnt   (cnt)
            );

            clkdiv_shape #(.DIV(DIVIDE), .CW(CNT_W)) u_shape (
                .clk_in(clk_in),
                .rst_n (rst_n),
                .ce    (ce),
                .clr   (clr),
                .cnt   (cnt),
                .out_q (out_q)
            );

            assign clk_out = out_q;
        end
    endgenerate
endmodule

// File: tb/clkdiv_top_bench.sv
// Bench: runs every divider setting side by side and checks them against
// patterns computed from the requirements.
module clkdiv_top_bench;
    localparam int NDIV = 9;
    localparam int WIN  = 48;
    // Each row: divisor, high cycles, low cycles.
    localparam int TBL [7][3] = '{
        '{2, 1, 1}, '{3, 1, 2}, '{4, 2, 2}, '{5, 2, 3},
        '{6, 3, 3}, '{7, 3, 4}, '{8, 4, 4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0;
    logic clr = 1'b0;
    logic [NDIV-1:0] outs;
    logic [NDIV-1:0] s_hi;
    logic [NDIV-1:0] s_lo;
    logic [NDIV-1:0] lvl;
    logic samp [2:8][1:WIN];
    int e_cnt = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NDIV; g++) begin : g_dut
        clkdiv_top #(.DIVIDE(g)) u_clkdiv_top (
            .clk_in (clk),
            .rst_n  (rst_n),
            .ce     (ce),
            .clr    (clr),
            .clk_out(outs[g])
        );
    end

    // Record one result, printing a FAIL line on mismatch.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One input cycle: sample 2 ns after the rising edge and 2 ns after the falling edge.
    task automatic step();
        bit adv;
        adv = ce && !clr && rst_n;
        @(posedge clk);
        #2 s_hi = outs;
        #5 s_lo = outs;
        if (adv) e_cnt++;
    endtask

    function automatic bit exp_lvl(input int n, input int e);
        return ((e - 1) % n) < (n / 2);
    endfunction

    // Check the pass-through output at both sample points of the last step.
    task automatic check_bypass(input string req);
        check(s_hi[0] == 1'b1 && s_lo[0] == 1'b0, req, {s_hi[0], s_lo[0]}, 2);
    endtask

    initial begin
        int errs;
        int hw;
        int lw;
        int k;
        // Reset state
        repeat (3) step();
        check(s_hi[8:1] == 8'h00, "R9 reset low", s_hi[8:1], 0);
        check_bypass("R1 in reset");
        rst_n = 1'b1;
        errs = 0;
        repeat (6) begin
            step();
            if (s_hi[8:1] != 8'h00 || s_lo[8:1] != 8'h00) errs++;
        end
        check(errs == 0, "R5 idle without ce", errs, 0);
        check_bypass("R1 ce low");

        // Run window
        ce = 1'b1;
        e_cnt = 0;
        errs = 0;
        for (int i = 1; i <= WIN; i++) begin
            step();
            for (int n = 2; n <= 8; n++) samp[n][i] = s_hi[n];
            if (i == 1 && (s_hi[1] || s_lo[1])) errs++;
            if (i >= 2 && (!s_hi[1] || s_lo[1])) errs++;
        end
        check(errs == 0, "R3 divide-by-1 follows clock", errs, 0);
        check_bypass("R1 running");

        // Table walk over divisors
        for (int t = 0; t < 7; t++) begin
            int n;
            n = TBL[t][0];
            errs = 0;
            for (int i = 1; i <= WIN; i++)
                if (samp[n][i] != exp_lvl(n, i)) errs++;
            check(errs == 0, $sformatf("R2 pattern div %0d", n), errs, 0);
            check(samp[n][1] == 1'b1, $sformatf("R4 first edge div %0d", n), samp[n][1], 1);
            hw = 0;
            k = 1;
            while (k <= WIN && samp[n][k]) begin hw++; k++; end
            lw = 0;
            while (k <= WIN && !samp[n][k]) begin lw++; k++; end
            check(hw == TBL[t][1], $sformatf("R2 high width div %0d", n), hw, TBL[t][1]);
            check(lw == TBL[t][2], $sformatf("R2 low width div %0d", n), lw, TBL[t][2]);
        end

        // Freeze with ce low
        lvl = s_hi;
        ce = 1'b0;
        errs = 0;
        for (int i = 1; i <= 6; i++) begin
            step();
            for (int n = 2; n <= 8; n++)
                if (s_hi[n] != lvl[n] || s_lo[n] != lvl[n]) errs++;
            if (i >= 2 && (s_hi[1] || s_lo[1])) errs++;
        end
        check(errs == 0, "R6 freeze", errs, 0);
        ce = 1'b1;
        errs = 0;
        for (int i = 1; i <= 12; i++) begin
            step();
            for (int n = 2; n <= 8; n++)
                if (s_hi[n] != exp_lvl(n, e_cnt)) errs++;
            if (i >= 2 && !s_hi[1]) errs++;
        end
        check(errs == 0, "R6 resume continues", errs, 0);

        // Asynchronous clear during a high phase of divide-by-8
        k = 0;
        while (!exp_lvl(8, e_cnt) && k < 16) begin step(); k++; end
        check(s_lo[8] == 1'b1, "R7 setup high", s_lo[8], 1);
        #1 clr = 1'b1;
        #1 check(outs[8:1] == 8'h00, "R7 async drop", outs[8:1], 0);
        errs = 0;
        repeat (3) begin
            step();
            if (s_hi[8:1] != 8'h00 || s_lo[8:1] != 8'h00) errs++;
        end
        check(errs == 0, "R7 held low", errs, 0);
        check_bypass("R1 during clr");

        // Restart after clear release
        clr = 1'b0;
        e_cnt = 0;
        errs = 0;
        for (int i = 1; i <= 24; i++) begin
            step();
            for (int n = 2; n <= 8; n++)
                if (s_hi[n] != exp_lvl(n, e_cnt)) errs++;
            if (i == 1 && s_hi[1]) errs++;
            if (i >= 2 && !s_hi[1]) errs++;
        end
        check(errs == 0, "R8 restart", errs, 0);

        // Synchronous reset mid-run
        rst_n = 1'b0;
        step();
        check(s_hi[8:2] == 7'h00, "R9 divided low after edge", s_hi[8:2], 0);
        check(s_lo[1] == 1'b0, "R9 divide-by-1 low at fall", s_lo[1], 0);
        step();
        check(s_hi[8:1] == 8'h00, "R9 all low", s_hi[8:1], 0);
        check_bypass("R1 reset mid-run");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule